// File: doc/BRIEF.md
# Resizable Reorder Buffer with Miss-Driven Capacity

This block keeps in-flight instructions in program order as a circular queue of result slots. A front end claims up to four slots per cycle at the tail and receives their tags. Execution units post results by tag. The retire stage takes finished slots from the head, again up to four per cycle, and always in order. A recovery flush empties the whole queue.

The queue normally uses only its lower partition, which is half of its 64 slots. The upper partition is unpowered in that state. While a data-cache miss is outstanding, instructions pile up behind the stalled load, so the block switches the upper partition on and grows to full size. There is one wake-up cycle before the extra slots count as free. When the miss period ends, the block keeps the upper partition until no live slot remains in it and both pointers sit in the lower half. Only then does it drop the partition and shrink back. The partition power-enable output tells the power controller when the upper slots may be gated.

Top module: `rob_resize_top`

## Requirements
- R1: After reset the queue is empty: `usedCount` is 0, `partEnable` is 0, `commitRdy` is 0, and the usable capacity is 32 slots.
- R2: A request for `allocCnt` slots (0 to 4) is granted in full (`allocOk`=1) only when at least that many slots are free at the current capacity. Otherwise nothing is allocated. A request of 0 always reports `allocOk`=1. Granted lane i receives the tag in `allocTags[6*i +: 6]`; tags are consecutive from the tail and wrap at the active capacity.
- R3: In the half-size state the capacity is 32 slots, so a request that exceeds the remaining free count stalls until slots retire or the queue grows.
- R4: A writeback marks a live slot finished and stores `wbData`. A writeback to a tag that holds no live instruction has no effect.
- R5: `commitRdy` bit i is 1 exactly when the head slots 0..i are all live and finished. `commitData[16*i +: 16]` carries the result of head slot i. A cycle retires min(`commitCnt`, number of ready slots) slots, in order.
- R6: A `flush` discards every slot, so `usedCount` is 0 after the edge, and cancels any allocation or retirement in that cycle.
- R7: When `missActive` is high in the half-size state, `partEnable` rises at the next edge. The capacity stays at 32 for that wake-up cycle and becomes 64 one edge later.
- R8: When `missActive` is low in the full-size state, the block returns to half size (and `partEnable` falls) only at an edge after which the queue is empty, or no live slot lies in the upper half and both pointers are below 32. Until then it stays at full size.
- R9: While `partEnable` is low, no slot of the upper partition is live. Writebacks addressed there are blocked by the partition select.
- R10: Whenever the queue becomes empty, both pointers return to slot 0. When the tail has wrapped to slot 0 at the half boundary and the queue then grows, allocation continues at slot 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| allocCnt | input | 3 | Number of slots requested this cycle (0..4) |
| allocOk | output | 1 | Request granted in full |
| allocTags | output | 24 | Tag of lane i in bits [6*i +: 6] |
| wbValid | input | 1 | Writeback strobe |
| wbTag | input | 6 | Slot written back |
| wbData | input | 16 | Result value |
| commitCnt | input | 3 | Number of slots the retire stage will take (0..4) |
| commitRdy | output | 4 | Prefix mask of finished head slots |
| commitData | output | 64 | Result of head slot i in bits [16*i +: 16] |
| flush | input | 1 | Discard all slots |
| missActive | input | 1 | A cache-miss period is in progress |
| partEnable | output | 1 | Upper partition powered |
| usedCount | output | 7 | Number of live slots |

## Verification
The assertions assume well-formed traffic at the ports. `allocCnt` and `commitCnt` never exceed 4. Writebacks name only slots that were handed out and have not yet retired, at most once each. The stimulus keeps to this: it posts results only for tags it has just been given, and it requests no more retirements than the ready mask permits, apart from one deliberate over-request that the block must clamp. Miss periods are held for whole cycles, so the grow and shrink sequences run without glitches on `missActive`.

// File: rtl/rob_resize_pkg.sv
package rob_resize_pkg;
  localparam int IW     = 4;
  localparam int DEPTH  = 64;
  localparam int DW     = 16;
  localparam int HALF   = DEPTH / 2;
  localparam int PTRW   = $clog2(DEPTH);
  localparam int BW     = PTRW + 1;
  localparam int CNTW   = $clog2(DEPTH + 1);
  localparam int LANEW  = $clog2(IW + 1);

  typedef enum logic [1:0] {
    SZ_HALF  = 2'd0,
    SZ_WAKE  = 2'd1,
    SZ_FULL  = 2'd2,
    SZ_DRAIN = 2'd3
  } sizeState_t;

  typedef struct packed {
    logic capFull;
    logic partEnable;
  } sizeStrobe_t;
endpackage

// File: rtl/rob_size_ctrl.sv
module rob_size_ctrl
  import rob_resize_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        missActive,
  input  logic        lowerOnly,
  output sizeStrobe_t strobe
);
  sizeState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      SZ_HALF: if (missActive) stateD = SZ_WAKE;
      SZ_WAKE: stateD = SZ_FULL;
      SZ_FULL, SZ_DRAIN: begin
        if (missActive)     stateD = SZ_FULL;
        else if (lowerOnly) stateD = SZ_HALF;
        else                stateD = SZ_DRAIN;
      end
      default: stateD = SZ_HALF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= SZ_HALF;
    else        stateQ <= stateD;
  end

  always_comb begin
    strobe.capFull    = (stateQ == SZ_FULL) || (stateQ == SZ_DRAIN);
    strobe.partEnable = (stateQ != SZ_HALF);
  end

  AST_MISS_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.partEnable && missActive) |=> (strobe.partEnable && !strobe.capFull)); // R7
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.partEnable && !strobe.capFull) |=> strobe.capFull); // R7
  AST_HOLD_IN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capFull && missActive) |=> strobe.capFull); // R8
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store
  import rob_resize_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  sizeStrobe_t        strobe,
  input  logic [LANEW-1:0]   allocCnt,
  output logic               allocOk,
  output logic [IW*PTRW-1:0] allocTags,
  input  logic               wbValid,
  input  logic [PTRW-1:0]    wbTag,
  input  logic [DW-1:0]      wbData,
  input  logic [LANEW-1:0]   commitCnt,
  output logic [IW-1:0]      commitRdy,
  output logic [IW*DW-1:0]   commitData,
  input  logic               flush,
  output logic [CNTW-1:0]    usedCount,
  output logic               lowerOnly
);
  localparam logic [BW-1:0] FULL_B = BW'(DEPTH);
  localparam logic [BW-1:0] HALF_B = BW'(HALF);

  logic [PTRW-1:0] headQ, tailQ;
  logic            wrapQ;
  logic [BW-1:0]   headLimQ;
  logic [CNTW-1:0] countQ;
  logic [DEPTH-1:0] liveQ, doneQ;
  logic [DW-1:0]   dataQ [DEPTH];

  logic [BW-1:0]   curBound, headBound, freeCnt;
  logic [BW-1:0]   tailSum, tailNext, headSum, headNext;
  logic [PTRW-1:0] effTail;
  logic            unwrap, effWrap, tailWrap, headWrap, wrapNext, emptyNext;
  logic [LANEW-1:0] allocN, commitN;
  logic [CNTW-1:0] countNext;
  logic [PTRW-1:0] tagIdx  [IW];
  logic [PTRW-1:0] headIdx [IW];
  logic            wbSel;

  function automatic logic [BW-1:0] wrapAdd(input logic [BW-1:0] base,
                                            input logic [BW-1:0] inc,
                                            input logic [BW-1:0] bound);
    logic [BW-1:0] s;
    s = base + inc;
    return (s >= bound) ? (s - bound) : s;
  endfunction

  // pointer arithmetic and grant
  always_comb begin
    curBound = strobe.capFull ? FULL_B : HALF_B;
    unwrap   = wrapQ && (tailQ == '0) && (headLimQ < curBound);
    effTail  = unwrap ? headLimQ[PTRW-1:0] : tailQ;
    effWrap  = wrapQ && !unwrap;
    freeCnt  = effWrap ? ({1'b0, headQ} - {1'b0, effTail})
                       : (curBound - {1'b0, effTail} + {1'b0, headQ});
    allocOk  = !flush && (BW'(allocCnt) <= freeCnt);
    allocN   = allocOk ? allocCnt : '0;
    for (int i = 0; i < IW; i++) begin
      logic [BW-1:0] t;
      t = wrapAdd({1'b0, effTail}, BW'(i), curBound);
      tagIdx[i] = t[PTRW-1:0];
      allocTags[i*PTRW +: PTRW] = t[PTRW-1:0];
    end
    tailSum  = {1'b0, effTail} + BW'(allocN);
    tailWrap = (tailSum >= curBound);
    tailNext = tailWrap ? (tailSum - curBound) : tailSum;
  end

  // head-side readiness and retirement
  always_comb begin
    logic prev;
    headBound = effWrap ? headLimQ : curBound;
    prev      = 1'b1;
    commitN   = '0;
    for (int i = 0; i < IW; i++) begin
      logic [BW-1:0] h;
      h = wrapAdd({1'b0, headQ}, BW'(i), headBound);
      headIdx[i]   = h[PTRW-1:0];
      commitRdy[i] = prev && (CNTW'(i) < countQ) && liveQ[headIdx[i]] && doneQ[headIdx[i]];
      prev         = commitRdy[i];
      commitData[i*DW +: DW] = dataQ[headIdx[i]];
      if (!flush && commitRdy[i] && (LANEW'(i) < commitCnt)) commitN = commitN + 1'b1;
    end
    headSum   = {1'b0, headQ} + BW'(commitN);
    headWrap  = (headSum >= headBound);
    headNext  = headWrap ? (headSum - headBound) : headSum;
    wrapNext  = tailWrap ? 1'b1 : (headWrap ? 1'b0 : effWrap);
    countNext = countQ + CNTW'(allocN) - CNTW'(commitN);
    emptyNext = flush || (countNext == '0);
    lowerOnly = emptyNext || (!wrapNext && (headNext < HALF_B) && (tailNext < HALF_B));
    wbSel     = (wbTag < PTRW'(HALF)) || strobe.partEnable;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headQ    <= '0;
      tailQ    <= '0;
      wrapQ    <= 1'b0;
      headLimQ <= HALF_B;
      countQ   <= '0;
      liveQ    <= '0;
      doneQ    <= '0;
    end else if (flush) begin
      headQ  <= '0;
      tailQ  <= '0;
      wrapQ  <= 1'b0;
      countQ <= '0;
      liveQ  <= '0;
    end else begin
      countQ <= countNext;
      if (emptyNext) begin
        headQ <= '0;
        tailQ <= '0;
        wrapQ <= 1'b0;
      end else begin
        headQ <= headNext[PTRW-1:0];
        tailQ <= tailNext[PTRW-1:0];
        wrapQ <= wrapNext;
      end
      if (tailWrap) headLimQ <= curBound;
      if (wbValid && wbSel && liveQ[wbTag]) doneQ[wbTag] <= 1'b1;
      for (int i = 0; i < IW; i++) begin
        if (LANEW'(i) < commitN) liveQ[headIdx[i]] <= 1'b0;
        if (LANEW'(i) < allocN) begin
          liveQ[tagIdx[i]] <= 1'b1;
          doneQ[tagIdx[i]] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wbValid && wbSel && liveQ[wbTag] && !flush) dataQ[wbTag] <= wbData;
  end

  assign usedCount = countQ;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    countQ <= CNTW'(curBound)); // R3
  AST_UPPER_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.partEnable |-> (liveQ[DEPTH-1:HALF] == '0)); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((countQ == '0) && (liveQ == '0))); // R6
  AST_SHRINK_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe.partEnable) |-> (!wrapQ && (headQ < PTRW'(HALF)) && (tailQ < PTRW'(HALF)))); // R8
  AST_COUNT_MATCHES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(liveQ) == int'(countQ)); // R2
endmodule

// File: rtl/rob_resize_top.sv
module rob_resize_top
  import rob_resize_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANEW-1:0]   allocCnt,
  output logic               allocOk,
  output logic [IW*PTRW-1:0] allocTags,
  input  logic               wbValid,
  input  logic [PTRW-1:0]    wbTag,
  input  logic [DW-1:0]      wbData,
  input  logic [LANEW-1:0]   commitCnt,
  output logic [IW-1:0]      commitRdy,
  output logic [IW*DW-1:0]   commitData,
  input  logic               flush,
  input  logic               missActive,
  output logic               partEnable,
  output logic [CNTW-1:0]    usedCount
);
  sizeStrobe_t strobe;
  logic        lowerOnly;

  rob_size_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .missActive (missActive),
    .lowerOnly  (lowerOnly),
    .strobe     (strobe)
  );

  rob_entry_store store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .allocCnt   (allocCnt),
    .allocOk    (allocOk),
    .allocTags  (allocTags),
    .wbValid    (wbValid),
    .wbTag      (wbTag),
    .wbData     (wbData),
    .commitCnt  (commitCnt),
    .commitRdy  (commitRdy),
    .commitData (commitData),
    .flush      (flush),
    .usedCount  (usedCount),
    .lowerOnly  (lowerOnly)
  );

  assign partEnable = strobe.partEnable;
endmodule

// File: tb/rob_resize_top_tb_top.sv
module rob_resize_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  allocCnt = '0;
  logic        allocOk;
  logic [23:0] allocTags;
  logic        wbValid = 1'b0;
  logic [5:0]  wbTag = '0;
  logic [15:0] wbData = '0;
  logic [2:0]  commitCnt = '0;
  logic [3:0]  commitRdy;
  logic [63:0] commitData;
  logic        flush = 1'b0;
  logic        missActive = 1'b0;
  logic        partEnable;
  logic [6:0]  usedCount;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  rob_resize_top dut_i (
    .clk(clk), .rst_n(rst_n), .allocCnt(allocCnt), .allocOk(allocOk),
    .allocTags(allocTags), .wbValid(wbValid), .wbTag(wbTag), .wbData(wbData),
    .commitCnt(commitCnt), .commitRdy(commitRdy), .commitData(commitData),
    .flush(flush), .missActive(missActive), .partEnable(partEnable),
    .usedCount(usedCount)
  );

  // {allocCnt, miss, expAllocOk, expCount, expPartEnable}
  localparam logic [12:0] VEC [23] = '{
    {3'd4,1'b0,1'b1,7'd0, 1'b0}, {3'd4,1'b0,1'b1,7'd4, 1'b0},
    {3'd4,1'b0,1'b1,7'd8, 1'b0}, {3'd4,1'b0,1'b1,7'd12,1'b0},
    {3'd4,1'b0,1'b1,7'd16,1'b0}, {3'd4,1'b0,1'b1,7'd20,1'b0},
    {3'd4,1'b0,1'b1,7'd24,1'b0}, {3'd3,1'b0,1'b1,7'd28,1'b0},
    {3'd2,1'b0,1'b0,7'd31,1'b0}, {3'd1,1'b0,1'b1,7'd31,1'b0},
    {3'd1,1'b1,1'b0,7'd32,1'b0}, {3'd1,1'b1,1'b0,7'd32,1'b1},
    {3'd4,1'b1,1'b1,7'd32,1'b1}, {3'd4,1'b1,1'b1,7'd36,1'b1},
    {3'd4,1'b1,1'b1,7'd40,1'b1}, {3'd4,1'b1,1'b1,7'd44,1'b1},
    {3'd4,1'b1,1'b1,7'd48,1'b1}, {3'd4,1'b1,1'b1,7'd52,1'b1},
    {3'd4,1'b1,1'b1,7'd56,1'b1}, {3'd4,1'b1,1'b1,7'd60,1'b1},
    {3'd1,1'b1,1'b0,7'd64,1'b1}, {3'd0,1'b0,1'b1,7'd64,1'b1},
    {3'd0,1'b0,1'b1,7'd64,1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #400000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 count", 32'(usedCount), 0);
    check("R1 partEnable", 32'(partEnable), 0);
    check("R1 commitRdy", 32'(commitRdy), 0);

    // table: fill at half size, stall, grow, fill at full size, end of miss
    for (int r = 0; r < 23; r++) begin
      allocCnt   = VEC[r][12:10];
      missActive = VEC[r][9];
      #1;
      check("R2 R3 R7 allocOk", 32'(allocOk), 32'(VEC[r][8]));
      check("R2 R3 usedCount", 32'(usedCount), 32'(VEC[r][7:1]));
      check("R7 R8 partEnable", 32'(partEnable), 32'(VEC[r][0]));
      if (r == 12) check("R10 tag after grow", 32'(allocTags[5:0]), 32);
      cyc();
    end
    allocCnt = '0;

    // flush while draining with a full upper partition
    flush = 1'b1;
    cyc();
    flush = 1'b0;
    #1;
    check("R6 count after flush", 32'(usedCount), 0);
    check("R8 shrink after flush", 32'(partEnable), 0);

    // writeback to a slot that is not live is ignored
    wbValid = 1'b1; wbTag = 6'd2; wbData = 16'h7777;
    cyc();
    wbValid = 1'b0;
    allocCnt = 3'd3;
    #1;
    check("R2 tag lane0", 32'(allocTags[5:0]), 0);
    check("R2 tag lane1", 32'(allocTags[11:6]), 1);
    check("R2 tag lane2", 32'(allocTags[17:12]), 2);
    cyc();
    allocCnt = '0;
    wbValid = 1'b1; wbTag = 6'd1; wbData = 16'hBEEF;
    cyc();
    wbTag = 6'd0; wbData = 16'h1111;
    #1;
    check("R5 head not finished", 32'(commitRdy), 0);
    cyc();
    wbValid = 1'b0;
    #1;
    check("R4 R5 ready prefix", 32'(commitRdy), 32'h3);
    check("R5 lane0 data", 32'(commitData[15:0]), 32'h1111);
    check("R5 lane1 data", 32'(commitData[31:16]), 32'hBEEF);
    commitCnt = 3'd3;
    cyc();
    commitCnt = '0;
    #1;
    check("R5 clamped retire", 32'(usedCount), 1);
    allocCnt = 3'd1;
    #1;
    check("R2 next tag", 32'(allocTags[5:0]), 3);
    cyc();
    allocCnt = '0;
    wbValid = 1'b1; wbTag = 6'd2; wbData = 16'h2222;
    cyc();
    wbTag = 6'd3; wbData = 16'h3333;
    cyc();
    wbValid = 1'b0;
    #1;
    check("R4 rewritten slot", 32'(commitData[15:0]), 32'h2222);
    commitCnt = 3'd2;
    cyc();
    commitCnt = '0;
    #1;
    check("R5 drained", 32'(usedCount), 0);
    allocCnt = 3'd1;
    #1;
    check("R10 pointers back to zero", 32'(allocTags[5:0]), 0);
    allocCnt = '0;

    // shrink must wait for the upper partition to drain
    missActive = 1'b1;
    cyc();
    cyc();
    for (int k = 0; k < 9; k++) begin
      allocCnt = 3'd4;
      cyc();
    end
    allocCnt = '0;
    missActive = 1'b0;
    cyc();
    for (int t = 0; t < 36; t++) begin
      wbValid = 1'b1; wbTag = 6'(t); wbData = 16'(t);
      cyc();
    end
    wbValid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      commitCnt = 3'd4;
      cyc();
    end
    commitCnt = '0;
    #1;
    check("R8 held while upper live", 32'(partEnable), 1);
    check("R8 remaining", 32'(usedCount), 4);
    check("R5 in-order head data", 32'(commitData[15:0]), 32);
    commitCnt = 3'd4;
    cyc();
    commitCnt = '0;
    #1;
    check("R8 count drained", 32'(usedCount), 0);
    check("R8 partition released", 32'(partEnable), 0);

    finishRun();
  end
endmodule